// File: doc/BRIEF.md
# Chained Interval Timer

This block holds three 16-bit down-counters that sit behind a byte-wide register interface. The counter on channel 2 is a divider. It steps once for every cycle in which `masterTick` is high. Each of its terminal counts moves channels 0 and 1 on by one step. Channel 0 is meant as a periodic tick source. Channel 1 is meant as a free-running timebase that raises an interrupt each time it wraps. Each of these two channels has its own sticky interrupt output, and software clears it through a write-one-to-clear register.

Software uses a control byte to pick a channel. That byte also either freezes the channel's count for a clean two-byte readout, or sets the channel's mode: rate generator or stopped. The 16-bit reload value is then written through the channel's data address as two bytes. Reads from a data address return the count one byte at a time, low byte first. Only one bus access is issued per cycle.

Top module: `tmr_chain`

## Requirements
- R1: After reset both interrupt outputs are low and every channel is stopped with count, reload and read data at zero. Ticks have no effect until a channel is programmed.
- R2: A write to address 3 is a control byte. Bits 7:6 select channel 0, 1 or 2, and the value 3 is ignored. Bits 5:4 give the command: 00 latches the count, 11 programs the mode from bits 3:1 (010 selects rate generator, any other value stops the channel), and 01 or 10 are ignored and leave all channel state untouched, including the read byte order.
- R3: Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. A program command resets the write order. The next data write supplies the reload low byte and the one after supplies the high byte. The high-byte write loads the count and starts counting only in rate-generator mode. Between the program command and the high byte the channel is stopped and its count is unchanged.
- R4: On each step of a running rate-generator channel, a count above 1 decrements (0 wraps to 0xFFFF). A count of 1 reloads the stored value and gives a terminal count for that step. A reload value N from 2 to 65535 therefore gives one terminal count every N steps, and 0 gives one every 65536 steps. A reload of 1 is not supported.
- R5: Channel 2 steps on every cycle with `masterTick` high. Channels 0 and 1 step only in the cycle of a channel 2 terminal count. The tick interrupt period is therefore reload0 × reload2 ticks.
- R6: A terminal count on channel 0 (channel 1) sets `tickIrq` (`baseIrq`) at that clock edge. The output stays high until it is cleared.
- R7: A write to address 4 clears `tickIrq` when bit 0 is 1 and `baseIrq` when bit 1 is 1, so 0x03 clears both. A clear overrides a terminal count in the same cycle.
- R8: A latch command freezes a copy of the count while the counter keeps running. The next two data reads of that channel return the copy's low byte and then its high byte, and the copy is released after the high byte. Further latch commands are ignored while a copy is held.
- R9: A data read puts a byte on `rdata` at the clock edge of the read and `rdata` holds it until the next data read. With no latched copy, successive reads alternate between the low and high byte of the live count, starting with the low byte after reset or a program command.
- R10: A channel programmed with a non-rate mode keeps its count frozen and never produces a terminal count or an interrupt.
- R11: Channel 1 with reload 0xFFFF and channel 2 with reload 2 raise `baseIrq` exactly 131070 ticks after the channel 2 high byte is written. This is the full 65535-step wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterTick | input | 1 | Step enable for the divider channel |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| tickIrq | output | 1 | Sticky interrupt from channel 0 |
| baseIrq | output | 1 | Sticky interrupt from channel 1 |

## Verification
The bench builds the block with the package defaults: three channels, 16-bit counts and 8-bit bytes. With the divider at its smallest correct period of 2, the complete 65535-step wrap of channel 1 takes about 131 thousand cycles, so it is measured end to end to the exact edge. A behavioural model follows every channel's count, latch and byte order and is compared on every cycle. Directed sequences hold the tick input low so that counts are frozen at values worked out by hand. Those sequences cover latch-while-counting, ignored commands, clear-against-set in one cycle and partial reload writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 2 * BYTE_W;
  localparam int NUM_CH  = 3;
  localparam int DIV_CH  = NUM_CH - 1;
  localparam int NUM_IRQ = NUM_CH - 1;
  localparam int ADDR_W  = 3;
  localparam int SEL_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(4);

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_WORD  = 2'b11;
  localparam logic [2:0] MODE_RATE = 3'b010;

  // strobes from the bus decoder to the counting datapath
  typedef struct packed {
    logic [NUM_CH-1:0]  cfgWr;
    logic               cfgRate;
    logic [NUM_CH-1:0]  latchCmd;
    logic [NUM_CH-1:0]  dataWr;
    logic [NUM_CH-1:0]  dataRd;
    logic [NUM_IRQ-1:0] clrMask;
    logic [BYTE_W-1:0]  wByte;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output tmrStrobe_t        strb
);
  logic [SEL_W-1:0] selField;
  logic [1:0]       accField;
  logic [2:0]       modeField;

  assign selField  = wdata[7:6];
  assign accField  = wdata[5:4];
  assign modeField = wdata[3:1];

  always_comb begin
    strb         = '0;
    strb.wByte   = wdata;
    strb.cfgRate = (modeField == MODE_RATE);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) begin
        strb.dataWr[i] = wrEn;
        strb.dataRd[i] = rdEn;
      end
      // selector value 3 matches no channel and is dropped (R2)
      if (wrEn && addr == ADDR_CTRL && selField == SEL_W'(i)) begin
        strb.latchCmd[i] = (accField == ACC_LATCH);
        strb.cfgWr[i]    = (accField == ACC_WORD);
      end
    end
    if (wrEn && addr == ADDR_CLR) strb.clrMask = wdata[NUM_IRQ-1:0];
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              step,
  input  logic              cfgWr,
  input  logic              cfgRate,
  input  logic              latchCmd,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [BYTE_W-1:0] wByte,
  output logic              tc,
  output logic [BYTE_W-1:0] rdByte
);
  logic [CNT_W-1:0]  count, reload, latchVal, shown;
  logic [BYTE_W-1:0] stage;
  logic running, modeRate, wrHi, rdHi, latched;

  assign tc     = step & running & (count == CNT_W'(1));
  assign shown  = latched ? latchVal : count;
  assign rdByte = rdHi ? shown[CNT_W-1:BYTE_W] : shown[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      reload   <= '0;
      latchVal <= '0;
      stage    <= '0;
      running  <= 1'b0;
      modeRate <= 1'b0;
      wrHi     <= 1'b0;
      rdHi     <= 1'b0;
      latched  <= 1'b0;
    end else if (cfgWr) begin
      running  <= 1'b0;
      modeRate <= cfgRate;
      wrHi     <= 1'b0;
      rdHi     <= 1'b0;
      latched  <= 1'b0;
    end else begin
      if (dataWr) begin
        if (!wrHi) begin
          stage <= wByte;
          wrHi  <= 1'b1;
        end else begin
          reload  <= {wByte, stage};
          count   <= {wByte, stage};
          running <= modeRate;
          wrHi    <= 1'b0;
        end
      end else if (step && running) begin
        count <= (count == CNT_W'(1)) ? reload : count - CNT_W'(1);
      end
      if (latchCmd && !latched) begin
        latched  <= 1'b1;
        latchVal <= count;
      end
      if (dataRd) begin
        rdHi <= ~rdHi;
        if (rdHi && latched) latched <= 1'b0;
      end
    end
  end

  // R10: a halted channel keeps its count
  a_r10_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !dataWr) |=> $stable(count));

  // R4: terminal count hands the stored value back to the counter
  a_r4_reload_on_tc: assert property (@(posedge clk) disable iff (!rstN)
    (tc && !dataWr && !cfgWr) |=> (count == $past(reload)));

  // R8: a held copy does not move until the high byte has been read
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !cfgWr && !dataRd) |=> (latched && $stable(latchVal)));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterTick,
  input  tmrStrobe_t         strb,
  output logic [NUM_IRQ-1:0] irq,
  output logic [BYTE_W-1:0]  rdata
);
  logic                divTc;
  logic [NUM_IRQ-1:0]  irqTc;
  logic [BYTE_W-1:0]   chByte [NUM_CH];
  logic [BYTE_W-1:0]   rdMux;

  tmr_chan uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .step     (masterTick),
    .cfgWr    (strb.cfgWr[DIV_CH]),
    .cfgRate  (strb.cfgRate),
    .latchCmd (strb.latchCmd[DIV_CH]),
    .dataWr   (strb.dataWr[DIV_CH]),
    .dataRd   (strb.dataRd[DIV_CH]),
    .wByte    (strb.wByte),
    .tc       (divTc),
    .rdByte   (chByte[DIV_CH])
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gCnt
    tmr_chan uChan (
      .clk      (clk),
      .rstN     (rstN),
      .step     (divTc),
      .cfgWr    (strb.cfgWr[g]),
      .cfgRate  (strb.cfgRate),
      .latchCmd (strb.latchCmd[g]),
      .dataWr   (strb.dataWr[g]),
      .dataRd   (strb.dataRd[g]),
      .wByte    (strb.wByte),
      .tc       (irqTc[g]),
      .rdByte   (chByte[g])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                irq[g] <= 1'b0;
      else if (strb.clrMask[g]) irq[g] <= 1'b0;
      else if (irqTc[g])        irq[g] <= 1'b1;
    end

    // R7: clear beats a same-cycle set
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrMask[g] |=> !irq[g]);
    // R6: flag stays up until cleared
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (irq[g] && !strb.clrMask[g]) |=> irq[g]);
    // R6: terminal count raises the flag
    a_r6_set_on_tc: assert property (@(posedge clk) disable iff (!rstN)
      (irqTc[g] && !strb.clrMask[g]) |=> irq[g]);
    // R5: chained channels only reach terminal count on a divider terminal count
    a_r5_chained_step: assert property (@(posedge clk) disable iff (!rstN)
      irqTc[g] |-> divTc);
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (strb.dataRd[i]) rdMux = rdMux | chByte[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdata <= '0;
    else if (|strb.dataRd) rdata <= rdMux;
  end

  // R9: read data only moves on a data read
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(|strb.dataRd) |=> $stable(rdata));
endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterTick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              tickIrq,
  output logic              baseIrq
);
  tmrStrobe_t         strb;
  logic [NUM_IRQ-1:0] irq;

  tmr_ctrl uCtrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .wdata (wdata),
    .strb  (strb)
  );

  tmr_datapath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .masterTick (masterTick),
    .strb       (strb),
    .irq        (irq),
    .rdata      (rdata)
  );

  assign tickIrq = irq[0];
  assign baseIrq = irq[1];
endmodule

// File: tb/tmr_chain_test.sv
module tmr_chain_test;
  logic clk = 1'b0, rstN = 1'b0, masterTick = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        tickIrq, baseIrq;

  tmr_chain uut (
    .clk(clk), .rstN(rstN), .masterTick(masterTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tickIrq(tickIrq), .baseIrq(baseIrq)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCnt[3], mRel[3], mRun[3], mRate[3], mWhi[3], mStg[3], mLat[3], mLv[3], mRhi[3];
  int mIrq[2], mRd;
  int tcv[3], stp, sel, acc, isCfg, isLat, isWr, isRd, newLat, oldCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin
        mCnt[c] = 0; mRel[c] = 0; mRun[c] = 0; mRate[c] = 0; mWhi[c] = 0;
        mStg[c] = 0; mLat[c] = 0; mLv[c] = 0; mRhi[c] = 0;
      end
      mIrq[0] = 0; mIrq[1] = 0; mRd = 0;
    end else begin
      tcv[2] = (masterTick && mRun[2] != 0 && mCnt[2] == 1) ? 1 : 0;
      for (int c = 0; c < 2; c++)
        tcv[c] = (tcv[2] != 0 && mRun[c] != 0 && mCnt[c] == 1) ? 1 : 0;
      sel = int'(wdata[7:6]);
      acc = int'(wdata[5:4]);
      if (rdEn && addr < 3) begin
        oldCnt = (mLat[addr] != 0) ? mLv[addr] : mCnt[addr];
        mRd = (mRhi[addr] != 0) ? (oldCnt >> 8) & 255 : oldCnt & 255;
      end
      for (int c = 0; c < 3; c++) begin
        stp   = (c == 2) ? int'(masterTick) : tcv[2];
        isCfg = (wrEn && addr == 3 && sel == c && acc == 3) ? 1 : 0;
        isLat = (wrEn && addr == 3 && sel == c && acc == 0) ? 1 : 0;
        isWr  = (wrEn && addr == c) ? 1 : 0;
        isRd  = (rdEn && addr == c) ? 1 : 0;
        if (isCfg != 0) begin
          mRun[c] = 0; mRate[c] = (wdata[3:1] == 3'b010) ? 1 : 0;
          mWhi[c] = 0; mRhi[c] = 0; mLat[c] = 0;
        end else begin
          oldCnt = mCnt[c];
          if (isWr != 0) begin
            if (mWhi[c] == 0) begin mStg[c] = int'(wdata); mWhi[c] = 1; end
            else begin
              mRel[c] = int'(wdata) * 256 + mStg[c];
              mCnt[c] = mRel[c]; mRun[c] = mRate[c]; mWhi[c] = 0;
            end
          end else if (stp != 0 && mRun[c] != 0) begin
            mCnt[c] = (mCnt[c] == 1) ? mRel[c] : (mCnt[c] + 65535) % 65536;
          end
          newLat = mLat[c];
          if (isLat != 0 && mLat[c] == 0) begin newLat = 1; mLv[c] = oldCnt; end
          if (isRd != 0) begin
            if (mRhi[c] != 0 && mLat[c] != 0) newLat = 0;
            mRhi[c] = 1 - mRhi[c];
          end
          mLat[c] = newLat;
        end
      end
      for (int k = 0; k < 2; k++) begin
        if (wrEn && addr == 4 && wdata[k]) mIrq[k] = 0;
        else if (tcv[k] != 0) mIrq[k] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && cyc > 0) begin
      chk("R6 model tickIrq", int'(tickIrq), mIrq[0]);
      chk("R6 model baseIrq", int'(baseIrq), mIrq[1]);
      chk("R9 model rdata", int'(rdata), mRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; v = int'(rdata);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); masterTick = 1'b1;
    repeat (n) @(negedge clk);
    masterTick = 1'b0;
  endtask

  task automatic waitTick(output int c);
    while (tickIrq !== 1'b1) @(negedge clk);
    c = cyc;
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int v, x0, x1, c1, c2, c3, t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and idle ticks
    chk("R1 tickIrq after reset", int'(tickIrq), 0);
    chk("R1 baseIrq after reset", int'(baseIrq), 0);
    rd(3'd0, v); chk("R1 ch0 low byte", v, 0);
    rd(3'd0, v); chk("R1 ch0 high byte", v, 0);
    ticks(20);
    chk("R1 no tickIrq while unprogrammed", int'(tickIrq), 0);
    chk("R1 no baseIrq while unprogrammed", int'(baseIrq), 0);

    // R4 R5 divider 3, channel 0 reload 4 -> 12 ticks per interrupt
    wr(3'd3, 8'hB4); wr(3'd2, 8'h03); wr(3'd2, 8'h00);
    wr(3'd3, 8'h34); wr(3'd0, 8'h04); wr(3'd0, 8'h00);
    @(negedge clk); masterTick = 1'b1;
    waitTick(c1);
    wr(3'd4, 8'h01);
    chk("R7 clear bit0 drops tickIrq", int'(tickIrq), 0);
    waitTick(c2);
    chk("R5 chained period 3x4", c2 - c1, 12);
    wr(3'd4, 8'h01);
    waitTick(c3);
    chk("R4 period repeats", c3 - c2, 12);

    // R6 R7 both flags, selective clears
    wr(3'd3, 8'h74); wr(3'd1, 8'h02); wr(3'd1, 8'h00);
    repeat (30) @(negedge clk);
    masterTick = 1'b0;
    chk("R6 tickIrq sticky", int'(tickIrq), 1);
    chk("R6 baseIrq sticky", int'(baseIrq), 1);
    wr(3'd4, 8'h02);
    chk("R7 0x02 clears baseIrq", int'(baseIrq), 0);
    chk("R7 0x02 keeps tickIrq", int'(tickIrq), 1);
    wr(3'd4, 8'h01);
    chk("R7 0x01 clears tickIrq", int'(tickIrq), 0);
    ticks(30);
    wr(3'd4, 8'h03);
    chk("R7 0x03 clears tickIrq", int'(tickIrq), 0);
    chk("R7 0x03 clears baseIrq", int'(baseIrq), 0);

    // R7 clear against a same-cycle terminal count (divider 2, channel 0 reload 2)
    wr(3'd3, 8'hB4); wr(3'd2, 8'h02); wr(3'd2, 8'h00);
    wr(3'd3, 8'h34); wr(3'd0, 8'h02); wr(3'd0, 8'h00);
    wr(3'd4, 8'h03);
    @(negedge clk); masterTick = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 no terminal count before 4th tick", int'(tickIrq), 0);
    addr = 3'd4; wdata = 8'h01; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; masterTick = 1'b0;
    chk("R7 clear wins over set", int'(tickIrq), 0);
    ticks(4);
    chk("R4 reload 2x2 fires on 4th tick", int'(tickIrq), 1);

    // R3 channel stopped between program command and high byte
    wr(3'd4, 8'h03);
    wr(3'd3, 8'hB4); wr(3'd2, 8'h02); wr(3'd2, 8'h00);
    wr(3'd3, 8'h74);
    rd(3'd1, x0); rd(3'd1, x1);
    wr(3'd1, 8'h34);
    ticks(8);
    rd(3'd1, v); chk("R3 count frozen low byte", v, x0);
    rd(3'd1, v); chk("R3 count frozen high byte", v, x1);
    wr(3'd1, 8'h12);

    // R8 latch while counting
    wr(3'd3, 8'h40);
    ticks(8);
    wr(3'd3, 8'h40);
    rd(3'd1, v); chk("R8 latched low byte", v, 8'h34);
    rd(3'd1, v); chk("R8 latched high byte", v, 8'h12);
    rd(3'd1, v); chk("R9 live low byte", v, 8'h30);
    rd(3'd1, v); chk("R9 live high byte", v, 8'h12);
    ticks(8);
    wr(3'd3, 8'h40);
    ticks(2);
    rd(3'd1, v); chk("R8 copy kept while counting, low", v, 8'h2C);
    rd(3'd1, v); chk("R8 copy kept while counting, high", v, 8'h12);

    // R2 ignored commands
    rd(3'd1, v); chk("R9 live low after release", v, 8'h2B);
    wr(3'd3, 8'h54);
    rd(3'd1, v); chk("R2 access code 01 ignored, order kept", v, 8'h12);
    wr(3'd3, 8'hF8);
    ticks(2);
    rd(3'd1, v); chk("R2 selector 3 ignored, low", v, 8'h2A);
    rd(3'd1, v); chk("R2 selector 3 ignored, high", v, 8'h12);

    // R10 stop mode
    wr(3'd3, 8'h78);
    wr(3'd4, 8'h03);
    ticks(40);
    rd(3'd1, v); chk("R10 stopped count low", v, 8'h2A);
    rd(3'd1, v); chk("R10 stopped count high", v, 8'h12);
    chk("R10 no baseIrq when stopped", int'(baseIrq), 0);
    wr(3'd3, 8'h38);
    wr(3'd4, 8'h03);
    ticks(40);
    chk("R10 no tickIrq when stopped", int'(tickIrq), 0);

    // R11 full wrap of channel 1
    wr(3'd4, 8'h03);
    wr(3'd3, 8'h74); wr(3'd1, 8'hFF); wr(3'd1, 8'hFF);
    wr(3'd3, 8'hB4); wr(3'd2, 8'h02);
    masterTick = 1'b1;
    wr(3'd2, 8'h00);
    t0 = cyc;
    while (cyc < t0 + 131069) @(negedge clk);
    chk("R11 no baseIrq one tick early", int'(baseIrq), 0);
    @(negedge clk);
    chk("R11 baseIrq after 65535 steps", int'(baseIrq), 1);
    masterTick = 1'b0;

    repeat (2) @(negedge clk);
    report();
  end
endmodule